// File: doc/BRIEF.md
# Programmable Energy Pulse Stretcher

The block widens single-cycle energy event strobes into output pulses whose length is set by software and counted in ticks of a slower timebase. Two primary outputs count their width in sample-period ticks; one auxiliary output counts in output-word-period ticks. An upstream energy accumulator supplies the strobes and the tick enables. A register front end supplies write strobes for the two width registers.

The primary width register applies only when the output format selects alternate-pulse or mechanical-counter operation. In every other format, each primary strobe yields a pulse one sample tick long. The auxiliary width register resets to zero, and zero selects a built-in default width fixed at build time. The block samples the width and the format when a pulse starts, so a change reaches only the next pulse. A strobe that arrives while a pulse is busy is remembered and replayed once the channel is free.

Top module: `epulse_stretch`

## Requirements
- R1: After a synchronous reset, every pulse output is low, the primary width register holds PRI_RST (512 by default) and the auxiliary width register holds 0.
- R2: With out_fmt equal to 1 (alternate) or 2 (mechanical), a primary strobe on an idle channel raises that output on the next cycle. The output stays high until the cycle after the Nth sample tick, where N is the primary width register.
- R3: With out_fmt equal to 0 or 3, a primary pulse ends after the first sample tick that follows its start, whatever the width register holds.
- R4: In a stretching format, a primary width register value of 0 behaves as a width of one sample tick.
- R5: An auxiliary strobe gives a pulse lasting N output-word ticks, where N is the auxiliary register value, for any value from 1 up to 8388607.
- R6: While the auxiliary register holds 0, an auxiliary pulse lasts AUX_DEF output-word ticks.
- R7: A strobe that arrives while its channel is high, or in the low gap after a pulse, is kept as one pending request. Further strobes are absorbed into it. The channel starts the new pulse at the first tick of its own timebase after the old pulse ends.
- R8: A register write or a format change during a pulse leaves that pulse's length unchanged. The next pulse uses the new setting.
- R9: Every channel runs independently on its own strobe and tick.
- R10: Reset asserted during a pulse drops all outputs on the next cycle and discards pending requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_tick | input | 1 | One-cycle enable per sample period |
| owr_tick | input | 1 | One-cycle enable per output-word period |
| pri_evt | input | NUM_PRI | Primary event strobes, one per channel |
| aux_evt | input | 1 | Auxiliary event strobe |
| out_fmt | input | 2 | Output format: 0 normal, 1 alternate, 2 mechanical, 3 normal |
| pri_width_we | input | 1 | Write enable for the primary width register |
| pri_width_wdata | input | PRI_W | Primary width, in sample periods |
| aux_width_we | input | 1 | Write enable for the auxiliary width register |
| aux_width_wdata | input | AUX_W | Auxiliary width, in output-word periods; 0 selects AUX_DEF |
| pri_pulse | output | NUM_PRI | Stretched primary pulses |
| aux_pulse | output | 1 | Stretched auxiliary pulse |

## Verification
The bench builds the block with AUX_DEF set to 2 and all other parameters at their defaults. These are two primary channels, 24- and 23-bit width registers and a primary reset width of 512. The short default makes the zero-value auxiliary path visible within a few cycles. The untouched reset width lets a full 512-tick pulse be measured, both after power-up and after a reset partway through a pulse. At run time the bench changes the tick periods between 1, 3 and 5 cycles. This places strobes at different phases relative to the ticks. The largest auxiliary value is loaded to show that a very long pulse holds and that reset then cuts it short.

// File: rtl/epulse_pkg.sv
`timescale 1ns/1ps
package epulse_pkg;

    typedef enum logic [1:0] {
        FMT_NORMAL = 2'd0,
        FMT_ALT    = 2'd1,
        FMT_MECH   = 2'd2,
        FMT_PLAIN  = 2'd3
    } out_fmt_e;

    typedef enum logic [1:0] {
        CH_IDLE   = 2'd0,
        CH_ACTIVE = 2'd1,
        CH_GAP    = 2'd2
    } ch_state_e;

    // Formats in which the programmed primary width is honoured.
    function automatic logic fmt_stretches(input logic [1:0] fmt);
        return (fmt == FMT_ALT) || (fmt == FMT_MECH);
    endfunction

endpackage

// File: rtl/epulse_cfg.sv
`timescale 1ns/1ps
// Width registers and effective-width selection.
module epulse_cfg
    import epulse_pkg::*;
#(
    parameter int PRI_W   = 24,
    parameter int AUX_W   = 23,
    parameter int CNT_W   = 24,
    parameter int PRI_RST = 512,
    parameter int AUX_DEF = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       out_fmt,
    input  logic             pri_width_we,
    input  logic [PRI_W-1:0] pri_width_wdata,
    input  logic             aux_width_we,
    input  logic [AUX_W-1:0] aux_width_wdata,
    output logic [CNT_W-1:0] pri_width_eff,
    output logic [CNT_W-1:0] aux_width_eff
);

    typedef struct packed {
        logic [PRI_W-1:0] pri;
        logic [AUX_W-1:0] aux;
    } cfg_t;

    localparam cfg_t CFG_RST = '{pri: PRI_W'(PRI_RST), aux: '0};

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (pri_width_we) cfg_d.pri = pri_width_wdata;
        if (aux_width_we) cfg_d.aux = aux_width_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= CFG_RST;
        else     cfg_q <= cfg_d;
    end

    always_comb begin
        if (!fmt_stretches(out_fmt) || (cfg_q.pri == '0))
            pri_width_eff = CNT_W'(1);
        else
            pri_width_eff = CNT_W'(cfg_q.pri);

        if (cfg_q.aux == '0)
            aux_width_eff = CNT_W'(AUX_DEF);
        else
            aux_width_eff = CNT_W'(cfg_q.aux);
    end

endmodule

// File: rtl/epulse_chan.sv
`timescale 1ns/1ps
// One pulse channel: idle, active for width ticks, one-tick gap, pending replay.
module epulse_chan
    import epulse_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             evt,
    input  logic [CNT_W-1:0] width_eff,
    output logic             pulse
);

    typedef struct packed {
        ch_state_e        st;
        logic [CNT_W-1:0] cnt;
        logic             pend;
    } ch_t;

    localparam ch_t CH_RST = '{st: CH_IDLE, cnt: '0, pend: 1'b0};

    ch_t ch_d, ch_q;

    always_comb begin
        ch_d = ch_q;
        unique case (ch_q.st)
            CH_IDLE: begin
                if (evt) begin
                    ch_d.st  = CH_ACTIVE;
                    ch_d.cnt = width_eff;
                end
            end
            CH_ACTIVE: begin
                ch_d.pend = ch_q.pend | evt;
                if (tick) begin
                    if (ch_q.cnt <= CNT_W'(1)) ch_d.st  = CH_GAP;
                    else                       ch_d.cnt = ch_q.cnt - CNT_W'(1);
                end
            end
            CH_GAP: begin
                if (tick) begin
                    if (ch_q.pend | evt) begin
                        ch_d.st   = CH_ACTIVE;
                        ch_d.cnt  = width_eff;
                        ch_d.pend = 1'b0;
                    end else begin
                        ch_d.st = CH_IDLE;
                    end
                end else begin
                    ch_d.pend = ch_q.pend | evt;
                end
            end
            default: ch_d = CH_RST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ch_q <= CH_RST;
        else     ch_q <= ch_d;
    end

    assign pulse = (ch_q.st == CH_ACTIVE);

endmodule

// File: rtl/epulse_stretch.sv
`timescale 1ns/1ps
module epulse_stretch
    import epulse_pkg::*;
#(
    parameter int NUM_PRI = 2,
    parameter int PRI_W   = 24,
    parameter int AUX_W   = 23,
    parameter int PRI_RST = 512,
    parameter int AUX_DEF = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               smp_tick,
    input  logic               owr_tick,
    input  logic [NUM_PRI-1:0] pri_evt,
    input  logic               aux_evt,
    input  logic [1:0]         out_fmt,
    input  logic               pri_width_we,
    input  logic [PRI_W-1:0]   pri_width_wdata,
    input  logic               aux_width_we,
    input  logic [AUX_W-1:0]   aux_width_wdata,
    output logic [NUM_PRI-1:0] pri_pulse,
    output logic               aux_pulse
);

    localparam int CNT_W = (PRI_W > AUX_W) ? PRI_W : AUX_W;

    logic [CNT_W-1:0] pri_width_eff;
    logic [CNT_W-1:0] aux_width_eff;

    epulse_cfg #(
        .PRI_W  (PRI_W),
        .AUX_W  (AUX_W),
        .CNT_W  (CNT_W),
        .PRI_RST(PRI_RST),
        .AUX_DEF(AUX_DEF)
    ) u_cfg (
        .clk            (clk),
        .rst            (rst),
        .out_fmt        (out_fmt),
        .pri_width_we   (pri_width_we),
        .pri_width_wdata(pri_width_wdata),
        .aux_width_we   (aux_width_we),
        .aux_width_wdata(aux_width_wdata),
        .pri_width_eff  (pri_width_eff),
        .aux_width_eff  (aux_width_eff)
    );

    for (genvar g = 0; g < NUM_PRI; g++) begin : g_pri
        epulse_chan #(.CNT_W(CNT_W)) u_chan (
            .clk      (clk),
            .rst      (rst),
            .tick     (smp_tick),
            .evt      (pri_evt[g]),
            .width_eff(pri_width_eff),
            .pulse    (pri_pulse[g])
        );
    end

    epulse_chan #(.CNT_W(CNT_W)) u_aux (
        .clk      (clk),
        .rst      (rst),
        .tick     (owr_tick),
        .evt      (aux_evt),
        .width_eff(aux_width_eff),
        .pulse    (aux_pulse)
    );

endmodule

// File: rtl/epulse_stretch_chk.sv
`timescale 1ns/1ps
module epulse_stretch_chk #(
    parameter int NUM_PRI = 2
) (
    input logic               clk,
    input logic               rst,
    input logic               smp_tick,
    input logic               owr_tick,
    input logic [NUM_PRI-1:0] pri_evt,
    input logic               aux_evt,
    input logic [NUM_PRI-1:0] pri_pulse,
    input logic               aux_pulse
);

    // R1 / R10: reset clears every output on the following cycle
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> ((pri_pulse == '0) && !aux_pulse));

    for (genvar g = 0; g < NUM_PRI; g++) begin : g_chk
        // R2: a primary pulse only ends on a sample tick
        a_r2_end_on_tick: assert property (@(posedge clk) disable iff (rst)
            $fell(pri_pulse[g]) |-> ($past(smp_tick) || $past(rst)));
        // R7: a primary pulse starts from a strobe or from a pending replay on a tick
        a_r7_pri_start_cause: assert property (@(posedge clk) disable iff (rst)
            $rose(pri_pulse[g]) |-> ($past(pri_evt[g]) || $past(smp_tick)));
    end

    // R5: the auxiliary pulse only ends on an output-word tick
    a_r5_aux_end_on_owr: assert property (@(posedge clk) disable iff (rst)
        $fell(aux_pulse) |-> ($past(owr_tick) || $past(rst)));

    // R7: the auxiliary pulse starts from a strobe or from a pending replay on a tick
    a_r7_aux_start_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(aux_pulse) |-> ($past(aux_evt) || $past(owr_tick)));

endmodule

bind epulse_stretch epulse_stretch_chk #(.NUM_PRI(NUM_PRI)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .smp_tick (smp_tick),
    .owr_tick (owr_tick),
    .pri_evt  (pri_evt),
    .aux_evt  (aux_evt),
    .pri_pulse(pri_pulse),
    .aux_pulse(aux_pulse)
);

// File: tb/test_epulse_stretch.sv
`timescale 1ns/1ps
module test_epulse_stretch;

    localparam int NP = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_tick = 1'b0;
    logic        owr_tick = 1'b0;
    logic [1:0]  pri_evt = '0;
    logic        aux_evt = 1'b0;
    logic [1:0]  out_fmt = 2'd0;
    logic        pwe = 1'b0;
    logic [23:0] pwd = '0;
    logic        awe = 1'b0;
    logic [22:0] awd = '0;
    logic [1:0]  pri_pulse;
    logic        aux_pulse;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    epulse_stretch #(.AUX_DEF(2)) i_epulse_stretch (
        .clk(clk), .rst(rst), .smp_tick(smp_tick), .owr_tick(owr_tick),
        .pri_evt(pri_evt), .aux_evt(aux_evt), .out_fmt(out_fmt),
        .pri_width_we(pwe), .pri_width_wdata(pwd),
        .aux_width_we(awe), .aux_width_wdata(awd),
        .pri_pulse(pri_pulse), .aux_pulse(aux_pulse)
    );

    // Tick generators, driven on the falling edge
    int smp_per = 1, owr_per = 1, smp_cnt = 0, owr_cnt = 0;
    always @(negedge clk) begin
        if (smp_cnt + 1 >= smp_per) begin smp_cnt = 0; smp_tick = 1'b1; end
        else begin smp_cnt++; smp_tick = 1'b0; end
        if (owr_cnt + 1 >= owr_per) begin owr_cnt = 0; owr_tick = 1'b1; end
        else begin owr_cnt++; owr_tick = 1'b0; end
    end

    // Behavioural reference: index 0..1 primary, 2 auxiliary
    int preg = 512, areg = 0;
    int phase[3] = '{0, 0, 0};   // 0 idle, 1 high, 2 waiting gap
    int left[3]  = '{0, 0, 0};
    bit want[3]  = '{0, 0, 0};
    bit exp_out[3] = '{0, 0, 0};

    always @(posedge clk) begin
        if (rst) begin
            preg = 512; areg = 0;
            for (int i = 0; i < 3; i++) begin
                phase[i] = 0; left[i] = 0; want[i] = 0;
            end
        end else begin
            for (int i = 0; i < 3; i++) begin
                int w; bit tk; bit ev;
                if (i < 2) begin
                    w  = ((out_fmt == 2'd1 || out_fmt == 2'd2) && preg != 0) ? preg : 1;
                    tk = smp_tick; ev = pri_evt[i];
                end else begin
                    w  = (areg == 0) ? 2 : areg;
                    tk = owr_tick; ev = aux_evt;
                end
                if (phase[i] == 0) begin
                    if (ev) begin phase[i] = 1; left[i] = w; end
                end else if (phase[i] == 1) begin
                    want[i] = want[i] | ev;
                    if (tk) begin
                        left[i] = left[i] - 1;
                        if (left[i] == 0) phase[i] = 2;
                    end
                end else begin
                    if (tk) begin
                        if (want[i] || ev) begin phase[i] = 1; left[i] = w; want[i] = 0; end
                        else phase[i] = 0;
                    end else want[i] = want[i] | ev;
                end
            end
            if (pwe) preg = int'(pwd);
            if (awe) areg = int'(awd);
        end
        for (int i = 0; i < 3; i++) exp_out[i] = (phase[i] == 1);
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Cycle-by-cycle comparison against the reference
    always @(negedge clk) begin
        if (!done) begin
            chk(pri_pulse[0] === exp_out[0], cur_req, "pri_pulse[0]", longint'(pri_pulse[0]), longint'(exp_out[0]));
            chk(pri_pulse[1] === exp_out[1], cur_req, "pri_pulse[1]", longint'(pri_pulse[1]), longint'(exp_out[1]));
            chk(aux_pulse === exp_out[2], cur_req, "aux_pulse", longint'(aux_pulse), longint'(exp_out[2]));
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe(input logic [1:0] p, input logic a);
        @(negedge clk); pri_evt = p; aux_evt = a;
        @(negedge clk); pri_evt = '0; aux_evt = 1'b0;
    endtask

    task automatic wr_pri(input logic [23:0] v);
        @(negedge clk); pwe = 1'b1; pwd = v;
        @(negedge clk); pwe = 1'b0;
    endtask

    task automatic wr_aux(input logic [22:0] v);
        @(negedge clk); awe = 1'b1; awd = v;
        @(negedge clk); awe = 1'b0;
    endtask

    // Counts high cycles of the selected output, starting at the current negedge
    task automatic measure(input int sel, input int expv, input string req);
        int n = 0;
        while ((sel == 2 ? aux_pulse : pri_pulse[sel]) === 1'b1 && n < 4000) begin
            n++; @(negedge clk);
        end
        chk(n == expv, req, "measured pulse length", n, expv);
    endtask

    initial begin
        idle(3);
        chk(pri_pulse === 2'b00 && aux_pulse === 1'b0, "R1", "outputs in reset",
            {pri_pulse, aux_pulse}, 0);
        @(negedge clk); rst = 1'b0;

        // R1/R2: reset width of 512 in alternate format, tick every cycle
        cur_req = "R2"; out_fmt = 2'd1; smp_per = 1; owr_per = 1;
        strobe(2'b01, 1'b0);
        measure(0, 512, "R1");
        idle(3);

        // R6: auxiliary default width (register still 0)
        cur_req = "R6";
        strobe(2'b00, 1'b1);
        measure(2, 2, "R6");
        idle(3);

        // R2/R5: programmed widths with slower ticks, mechanical format
        cur_req = "R2"; smp_per = 3; owr_per = 5; out_fmt = 2'd2;
        wr_pri(24'd4); wr_aux(23'd3);
        strobe(2'b01, 1'b0); idle(20);
        cur_req = "R5";
        strobe(2'b00, 1'b1); idle(25);

        // R9: both primaries and aux, staggered
        cur_req = "R9";
        strobe(2'b01, 1'b1); idle(2); strobe(2'b10, 1'b0); idle(30);

        // R3: normal formats ignore the width register
        cur_req = "R3"; out_fmt = 2'd0;
        strobe(2'b11, 1'b0); idle(8);
        out_fmt = 2'd3; idle(1);
        strobe(2'b01, 1'b0); idle(8);

        // R4: zero primary width in a stretching format
        cur_req = "R4"; out_fmt = 2'd1; wr_pri(24'd0);
        strobe(2'b10, 1'b0); idle(8);

        // R7: strobes during a pulse collapse to one replay
        cur_req = "R7"; wr_pri(24'd3);
        strobe(2'b01, 1'b1); idle(1); strobe(2'b01, 1'b1); strobe(2'b01, 1'b0);
        idle(60);

        // R8: change width and format while a pulse is high
        cur_req = "R8"; wr_pri(24'd5);
        strobe(2'b11, 1'b1); idle(2);
        out_fmt = 2'd0; wr_pri(24'd2); wr_aux(23'd1);
        idle(40);
        strobe(2'b01, 1'b1); idle(20);
        out_fmt = 2'd1; strobe(2'b10, 1'b0); idle(20);

        // R5: largest auxiliary value holds a long pulse; R10: reset cuts it
        cur_req = "R5"; owr_per = 1; wr_aux(23'h7FFFFF);
        strobe(2'b01, 1'b1); idle(300);
        cur_req = "R10";
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        chk(pri_pulse === 2'b00 && aux_pulse === 1'b0, "R10", "outputs after mid-pulse reset",
            {pri_pulse, aux_pulse}, 0);
        @(negedge clk); rst = 1'b0;
        smp_per = 1; out_fmt = 2'd2;
        strobe(2'b10, 1'b1);
        measure(1, 512, "R10");
        idle(5);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule